// File: doc/BRIEF.md
# Strap-Selected Segment Address Port

This block decides, once per reset, how many of the upper address lines (A16 and above) are driven out of the chip on an 8-bit port. Two strap pins are sampled on every clock edge while reset is held, and the last value seen before release is kept in a read-only configuration register. That value does not move again until the next reset, and nothing software does can alter it.

The port is split pin by pin. Pins below the selected line count carry segment address bits with their output enables forced on. Pins above that count act as ordinary general-purpose I/O. Each of those pins has a direction bit and a data bit that software writes, and its pad level is readable. The internal address stays 24 bits wide in every configuration. The whole address is forwarded unchanged so that chip-select logic can decode it, even when fewer lines leave the chip.

All interfaces are plain level signals. Nothing here streams data, so the block has no valid/ready handshake and no back-pressure. A software write is one cycle with a write-enable high.

Top module: `seg_port_cfg`

## Requirements
- R1: On each rising clock edge while `rst_n` is low, the straps are captured into `rcfg_o`. After `rst_n` goes high, `rcfg_o` keeps the last captured value regardless of later strap activity.
- R2: Writes to the direction or data registers never change `rcfg_o` or the set of pins carrying address bits.
- R3: With `rcfg_o` = 2'b11 (no pull-downs fitted), pins 0..1 output A16..A17 with enables on, which gives 256 KB of directly reachable space.
- R4: With `rcfg_o` = 2'b10, all pins 0..7 output A16..A23 with enables on, which gives 16 MB.
- R5: With `rcfg_o` = 2'b01, no pin carries an address bit and every pin is GPIO, which limits direct access to 64 KB.
- R6: With `rcfg_o` = 2'b00, pins 0..3 output A16..A19 with enables on, which gives 1 MB.
- R7: Address pins have their enables on from the first cycle after reset, with no software write. This holds even where the direction bit for that pin is 0.
- R8: `cs_addr_o` always equals the full 24-bit `int_addr_i`, whatever the strap setting.
- R9: On a GPIO pin, the enable equals its direction bit (1 = drive) and the driven value equals its data bit. `gpio_in_o` shows the pad levels of `pad_in_i`.
- R10: While `rst_n` is low, every bit of `pad_oe_o` is 0.
- R11: Reset clears the direction and data registers to 0. Each register loads `sw_wdata_i` on a clock edge where its write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; straps are sampled while low |
| strap_i | input | 2 | Segment-line selection straps |
| int_addr_i | input | 24 | Full internal address |
| sw_dir_we_i | input | 1 | Load direction register from `sw_wdata_i` |
| sw_out_we_i | input | 1 | Load data register from `sw_wdata_i` |
| sw_wdata_i | input | 8 | Software write data |
| pad_in_i | input | 8 | Pad levels seen at the port |
| pad_out_o | output | 8 | Pad drive values |
| pad_oe_o | output | 8 | Pad output enables (1 = drive) |
| gpio_in_o | output | 8 | GPIO input readback |
| rcfg_o | output | 2 | Latched strap configuration (read-only) |
| cs_addr_o | output | 24 | Full address forwarded for chip-select decoding |

## Verification
The bench moves the straps after reset is released. A design that kept sampling them would change its line count, or show a new `rcfg_o`, in the middle of operation. Each of the four encodings is run with all-ones direction and data registers and then with all-zeros. An off-by-one in the pin boundary, or a direction bit that overrides an address pin, shows up as a wrong enable or a wrong level on the first pin above or below the boundary. Address patterns set bits above the exported range, which catches designs that truncate the forwarded address or shift the wrong bits onto the pins. Enables are checked in the middle of reset with the direction register already set to all ones. A design that does not gate the enables with reset would drive against the straps at that point.

// File: rtl/seg_cfg_pkg.sv
package seg_cfg_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 24;
  localparam int SEG_BASE = 16;
  localparam int STRAP_W  = 2;
  localparam int CNT_W    = $clog2(PORT_W + 1);

  typedef logic [STRAP_W-1:0] strap_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // Strap code to number of exported segment lines
  function automatic cnt_t seg_count(strap_t code);
    case (code)
      2'b11:   return cnt_t'(2);
      2'b10:   return cnt_t'(PORT_W);
      2'b01:   return cnt_t'(0);
      default: return cnt_t'(4);
    endcase
  endfunction
endpackage

// File: rtl/seg_strap_latch.sv
module seg_strap_latch
  import seg_cfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t strap_i,
  output strap_t cfg_o
);
  strap_t cfg_q;

  // Sample while reset is held, freeze once released
  always_ff @(posedge clk)
    if (!rst_n) cfg_q <= strap_i;

  assign cfg_o = cfg_q;

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q));
endmodule

// File: rtl/seg_gpio_regs.sv
module seg_gpio_regs
  import seg_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_we_i,
  input  logic              out_we_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] out_o
);
  logic [PORT_W-1:0] dir_q, out_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= wdata_i;
      if (out_we_i) out_q <= wdata_i;
    end

  assign dir_o = dir_q;
  assign out_o = out_q;

  // R11
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we_i |=> $stable(dir_q));
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we_i |=> $stable(out_q));
endmodule

// File: rtl/seg_pin_mux.sv
module seg_pin_mux
  import seg_cfg_pkg::*;
(
  input  logic              rst_n,
  input  cnt_t              seg_cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic [PORT_W-1:0] out_i,
  output logic [PORT_W-1:0] pad_out_o,
  output logic [PORT_W-1:0] pad_oe_o
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic is_addr;
    assign is_addr      = cnt_t'(i) < seg_cnt_i;
    assign pad_out_o[i] = is_addr ? addr_i[SEG_BASE + i] : out_i[i];
    assign pad_oe_o[i]  = rst_n & (is_addr | dir_i[i]);
  end
endmodule

// File: rtl/seg_port_cfg.sv
module seg_port_cfg
  import seg_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_i,
  input  logic [23:0] int_addr_i,
  input  logic        sw_dir_we_i,
  input  logic        sw_out_we_i,
  input  logic [7:0]  sw_wdata_i,
  input  logic [7:0]  pad_in_i,
  output logic [7:0]  pad_out_o,
  output logic [7:0]  pad_oe_o,
  output logic [7:0]  gpio_in_o,
  output logic [1:0]  rcfg_o,
  output logic [23:0] cs_addr_o
);
  strap_t            cfg;
  cnt_t              seg_cnt;
  logic [PORT_W-1:0] dir, dout;

  seg_strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cfg_o(cfg)
  );

  seg_gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .dir_we_i(sw_dir_we_i), .out_we_i(sw_out_we_i),
    .wdata_i(sw_wdata_i), .dir_o(dir), .out_o(dout)
  );

  assign seg_cnt = seg_count(cfg);

  seg_pin_mux u_mux (
    .rst_n(rst_n), .seg_cnt_i(seg_cnt), .addr_i(int_addr_i), .dir_i(dir),
    .out_i(dout), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  assign rcfg_o    = cfg;
  assign gpio_in_o = pad_in_i;
  assign cs_addr_o = int_addr_i;

  // Expected address-pin mask, built independently of the per-pin compare
  logic [PORT_W:0] addr_mask;
  assign addr_mask = (({{PORT_W{1'b0}}, 1'b1}) << seg_cnt) - 1'b1;

  // R10
  always_comb
    if (rst_n === 1'b0)
      oe_reset_chk: assert (pad_oe_o == '0);

  // R7
  addr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & addr_mask[PORT_W-1:0]) == addr_mask[PORT_W-1:0]);

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_dir_we_i || sw_out_we_i) && $past(rst_n) |=> $stable(rcfg_o));
endmodule

// File: tb/seg_port_cfg_test.sv
module seg_port_cfg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  strap = 2'b11;
  logic [23:0] addr = '0;
  logic        dir_we = 0, out_we = 0;
  logic [7:0]  wdata = '0, pad_in = '0;
  logic [7:0]  pad_out, pad_oe, gpio_in;
  logic [1:0]  rcfg;
  logic [23:0] cs_addr;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  seg_port_cfg uut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .int_addr_i(addr),
    .sw_dir_we_i(dir_we), .sw_out_we_i(out_we), .sw_wdata_i(wdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .gpio_in_o(gpio_in), .rcfg_o(rcfg), .cs_addr_o(cs_addr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic int lines_of(logic [1:0] c);
    case (c)
      2'b11: return 2;
      2'b10: return 8;
      2'b01: return 0;
      default: return 4;
    endcase
  endfunction

  task automatic wr(bit is_dir, logic [7:0] v);
    @(negedge clk);
    wdata = v; dir_we = is_dir; out_we = !is_dir;
    @(negedge clk);
    dir_we = 0; out_we = 0;
  endtask

  // Reset with a given strap; verify R10 in reset, R1/R11 after release
  task automatic t_reset(logic [1:0] s);
    @(negedge clk);
    rst_n = 0; strap = ~s;
    @(negedge clk); strap = s;
    @(negedge clk);
    chk("R10 oe in reset", pad_oe, 8'h00);
    rst_n = 1;
    #2;
    chk("R1 captured strap", rcfg, s);
    chk("R11 dir reset", pad_oe, (8'h1 << lines_of(s)) - 8'h1);
    strap = ~s;
    repeat (3) @(negedge clk);
    chk("R1 strap ignored after reset", rcfg, s);
  endtask

  // Check pin mapping for current config with given dir/out contents
  task automatic t_map(string req, logic [1:0] s, logic [7:0] d, logic [7:0] o,
                       logic [23:0] a);
    int L = lines_of(s);
    logic [7:0] e_oe, e_out;
    wr(1, d); wr(0, o);
    @(negedge clk); addr = a; #2;
    for (int i = 0; i < 8; i++) begin
      e_oe[i]  = (i < L) ? 1'b1 : d[i];
      e_out[i] = (i < L) ? a[16+i] : o[i];
    end
    chk({req, " oe"}, pad_oe, e_oe);
    chk({req, " out"}, pad_out, e_out);
    chk("R8 cs addr", cs_addr, a);
    chk("R2 cfg after writes", rcfg, s);
  endtask

  task automatic t_gpio_in();
    @(negedge clk); pad_in = 8'h5A; #2;
    chk("R9 gpio in", gpio_in, 8'h5A);
    pad_in = 8'hC3; #2;
    chk("R9 gpio in", gpio_in, 8'hC3);
  endtask

  task automatic t_reset_drive();
    wr(1, 8'hFF);
    @(negedge clk); rst_n = 0; #2;
    chk("R10 oe async in reset", pad_oe, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset(2'b11);
    chk("R7 addr oe no write", pad_oe, 8'h03);
    t_map("R3", 2'b11, 8'hFF, 8'hFF, 24'h15_AAAA);
    t_map("R3", 2'b11, 8'h00, 8'h00, 24'hFE_0000);
    t_map("R9", 2'b11, 8'hA4, 8'h6C, 24'h02_1234);
    t_gpio_in();
    t_reset_drive();
    t_reset(2'b10);
    chk("R7 addr oe no write", pad_oe, 8'hFF);
    t_map("R4", 2'b10, 8'h00, 8'hFF, 24'hA5_0F0F);
    t_map("R4", 2'b10, 8'hFF, 8'h00, 24'h5A_FFFF);
    t_reset(2'b01);
    t_map("R5", 2'b01, 8'h00, 8'h00, 24'hFF_FFFF);
    t_map("R5", 2'b01, 8'hF0, 8'h3C, 24'h3F_0001);
    t_reset(2'b00);
    chk("R7 addr oe no write", pad_oe, 8'h0F);
    t_map("R6", 2'b00, 8'hFF, 8'hFF, 24'hF5_0000);
    t_map("R6", 2'b00, 8'h00, 8'h00, 24'h1A_8000);
    t_map("R9", 2'b00, 8'h90, 8'h50, 24'h0F_0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule